// File: doc/BRIEF.md
# Audio Zero Detect and Automute

This block watches the sample streams of four stereo DAC channels, which gives eight mono lanes. Each lane has a saturating run-length counter. The counter advances on every accepted all-zero sample and clears on any non-zero one. Once a lane has seen 1024 zero samples in a row, it is marked silent.

A 4-bit select code maps groups of lanes onto two active-high zero-flag outputs. These flags drive external muting. A lane whose channel is currently routed into the output summing stage never counts as silent for the flags.

With automute enabled, a stereo channel's mute output rises once both of its lanes become silent. Every mute output drops at the first non-zero sample seen on any lane.

Samples arrive as one packed beat holding all eight lanes, qualified by `smp_valid`. The block never applies back-pressure: `smp_ready` is tied high, and a beat is accepted on every clock edge where `smp_valid` is 1.

Top module: `audio_zero_mute`

## Requirements
- R1: Lane l occupies `smp_data[l*SAMPLE_W +: SAMPLE_W]`. Lane 2c is the left lane of channel c+1 and lane 2c+1 is its right lane. A lane becomes silent once RUN_LEN (default 1024) consecutive accepted samples on it were zero; after only RUN_LEN-1 zeros it is not silent.
- R2: An accepted non-zero sample restarts that lane's run from zero. The run saturates, so a lane stays silent for as long as zeros continue beyond RUN_LEN.
- R3: Select code 0000, the reset value, holds both flags at 0.
- R4: With code 0001, both flags mean "all eight lanes silent". With code 0010, flag 1 means "all left lanes silent" and flag 2 means "all right lanes silent". A flag is 1 only when every lane in its group is silent.
- R5: Codes 0011 to 0111 give flag 1 / flag 2 the following groups:
  - 0011: ch1 / ch2-4
  - 0100: ch1 / ch2
  - 0101: ch1 / ch3
  - 0110: ch1 / ch4
  - 0111: ch2 / ch3
- R6: Codes 1000 to 1111 drive both flags from a single lane: channel `code[1:0]`+1, left lane when `code[2]`=0 and right lane when `code[2]`=1.
- R7: A lane whose channel has its `chan_routed` bit set counts as not silent for the flags. Its run counter keeps running, so a routing change shows on the flags one cycle later.
- R8: Samples are counted only on beats with `smp_valid`=1. Non-zero data on a beat without `smp_valid` has no effect. `smp_ready` is always 1.
- R9: With `amute_en`=1, the mute bit of a channel rises one cycle after both of its lanes become silent. With `amute_en`=0, all mute bits are 0 from the next cycle.
- R10: An accepted beat with any non-zero lane clears all mute bits at that same edge. A mute bit rises again only when its channel newly becomes silent.
- R11: Synchronous reset `rst` clears all run counters, both flags and all mute bits.
- R12: The flags are registered and change one cycle after the run counters change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Sample beat valid |
| smp_ready | output | 1 | Always 1; the block accepts every beat |
| smp_data | input | 8*SAMPLE_W | Eight lane samples, lane l at bits l*SAMPLE_W |
| chan_routed | input | 4 | Per-channel "routed to output summer" bit |
| flag_sel | input | 4 | Zero-flag group select code |
| amute_en | input | 1 | Automute enable |
| zflag1 | output | 1 | Zero flag 1 |
| zflag2 | output | 1 | Zero flag 2 |
| mute | output | 4 | Per-channel mute, bit c for channel c+1 |

## Verification
The bench probes the run boundary at 1023 and 1024 zeros with idle beats carrying non-zero data mixed in. A design that counted idle beats, or compared against the threshold off by one, would raise the flag one sample early, or clear the run on an idle beat.

It then clears chosen lane patterns and sweeps all sixteen select codes against all sixteen routing masks. A wrong group table, a swapped left/right order or missing routing gating shows up as a flag mismatch.

The automute part checks that a non-zero sample on one lane clears every channel's mute, and that a mute does not re-arm until that channel has earned a fresh silent run. A design that re-armed from a still-saturated counter would show mute flickering back on.

// File: rtl/zd_pkg.sv
package zd_pkg;
  localparam int NCH   = 4;
  localparam int NLANE = 2 * NCH;

  typedef logic [NLANE-1:0] lane_vec_t;

  typedef struct packed {
    lane_vec_t f1;
    lane_vec_t f2;
  } flag_masks_t;

  // Lane groups per select code; lane 2c = channel c+1 left, 2c+1 = right.
  function automatic flag_masks_t sel_masks(input logic [3:0] code);
    flag_masks_t m;
    m = '0;
    if (code[3]) begin
      m.f1 = lane_vec_t'(1) << {code[1:0], code[2]};
      m.f2 = m.f1;
    end else begin
      case (code[2:0])
        3'd1: begin m.f1 = 8'hFF; m.f2 = 8'hFF; end
        3'd2: begin m.f1 = 8'h55; m.f2 = 8'hAA; end
        3'd3: begin m.f1 = 8'h03; m.f2 = 8'hFC; end
        3'd4: begin m.f1 = 8'h03; m.f2 = 8'h0C; end
        3'd5: begin m.f1 = 8'h03; m.f2 = 8'h30; end
        3'd6: begin m.f1 = 8'h03; m.f2 = 8'hC0; end
        3'd7: begin m.f1 = 8'h0C; m.f2 = 8'h30; end
        default: m = '0;
      endcase
    end
    return m;
  endfunction
endpackage

// File: rtl/zd_run_counter.sv
module zd_run_counter #(
  parameter int SAMPLE_W = 24,
  parameter int RUN_LEN  = 1024
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                valid,
  input  logic [SAMPLE_W-1:0] sample,
  output logic                silent
);
  localparam int CW = $clog2(RUN_LEN + 1);
  localparam logic [CW-1:0] LIMIT = CW'(RUN_LEN);

  logic [CW-1:0] run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= '0;
    end else if (valid) begin
      if (sample != '0)
        run_q <= '0;
      else if (run_q != LIMIT)
        run_q <= run_q + 1'b1;
    end
  end

  assign silent = (run_q == LIMIT);

  // R2: run never passes the limit
  p_run_bound_r2: assert property (@(posedge clk) disable iff (rst)
    run_q <= LIMIT);
  // R2: a non-zero accepted sample restarts the run
  p_nz_restart_r2: assert property (@(posedge clk) disable iff (rst)
    (valid && sample != '0) |=> run_q == '0);
  // R2: saturated run stays saturated through more zeros
  p_saturate_r2: assert property (@(posedge clk) disable iff (rst)
    (valid && sample == '0 && run_q == LIMIT) |=> silent);
  // R8: no accepted beat, no change
  p_idle_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !valid |=> $stable(run_q));
endmodule

// File: rtl/zd_flag_select.sv
module zd_flag_select
  import zd_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic [3:0] sel,
  input  lane_vec_t lane_ok,
  output logic      flag1,
  output logic      flag2
);
  flag_masks_t m;
  logic [1:0]  f_d;
  logic [1:0]  f_q;

  always_comb begin
    m = sel_masks(sel);
    f_d[0] = (m.f1 != '0) && ((lane_ok & m.f1) == m.f1);
    f_d[1] = (m.f2 != '0) && ((lane_ok & m.f2) == m.f2);
  end

  always_ff @(posedge clk) begin
    if (rst) f_q <= '0;
    else     f_q <= f_d;
  end

  assign flag1 = f_q[0];
  assign flag2 = f_q[1];

  // R3: code 0000 keeps both flags low
  p_off_code_r3: assert property (@(posedge clk) disable iff (rst)
    (sel == 4'd0) |=> (!flag1 && !flag2));
  // R4: all-lanes code gives equal flags, which imply every lane ok
  p_all_code_r4: assert property (@(posedge clk) disable iff (rst)
    (sel == 4'd1) |=> (flag1 == flag2) && (flag1 == $past(&lane_ok)));
  // R6: single-lane codes drive both flags identically
  p_single_same_r6: assert property (@(posedge clk) disable iff (rst)
    sel[3] |=> flag1 == flag2);
endmodule

// File: rtl/zd_automute.sv
module zd_automute #(
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           en,
  input  logic           any_nz,
  input  logic [NCH-1:0] ch_silent,
  output logic [NCH-1:0] mute
);
  logic [NCH-1:0] silent_q;
  logic [NCH-1:0] mute_q;
  logic [NCH-1:0] rise;

  assign rise = ch_silent & ~silent_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      silent_q <= '0;
      mute_q   <= '0;
    end else begin
      silent_q <= ch_silent;
      if (!en || any_nz) mute_q <= '0;
      else               mute_q <= mute_q | rise;
    end
  end

  assign mute = mute_q;

  // R9: disabled automute means no mute next cycle
  p_disabled_r9: assert property (@(posedge clk) disable iff (rst)
    !en |=> mute == '0);
  // R9: a muted channel is a silent channel
  p_mute_silent_r9: assert property (@(posedge clk) disable iff (rst)
    (mute & ~ch_silent) == '0);
  // R10: any non-zero accepted sample releases every mute
  p_release_r10: assert property (@(posedge clk) disable iff (rst)
    any_nz |=> mute == '0);
endmodule

// File: rtl/audio_zero_mute.sv
module audio_zero_mute
  import zd_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int RUN_LEN  = 1024
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      smp_valid,
  output logic                      smp_ready,
  input  logic [NLANE*SAMPLE_W-1:0] smp_data,
  input  logic [NCH-1:0]            chan_routed,
  input  logic [3:0]                flag_sel,
  input  logic                      amute_en,
  output logic                      zflag1,
  output logic                      zflag2,
  output logic [NCH-1:0]            mute
);
  lane_vec_t      lane_silent;
  lane_vec_t      lane_ok;
  lane_vec_t      lane_nz;
  logic [NCH-1:0] ch_silent;
  logic           any_nz;

  assign smp_ready = 1'b1;

  for (genvar l = 0; l < NLANE; l++) begin : g_lane
    zd_run_counter #(.SAMPLE_W(SAMPLE_W), .RUN_LEN(RUN_LEN)) u_run (
      .clk    (clk),
      .rst    (rst),
      .valid  (smp_valid),
      .sample (smp_data[l*SAMPLE_W +: SAMPLE_W]),
      .silent (lane_silent[l])
    );
    assign lane_nz[l] = (smp_data[l*SAMPLE_W +: SAMPLE_W] != '0);
    assign lane_ok[l] = lane_silent[l] & ~chan_routed[l/2];
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign ch_silent[c] = lane_silent[2*c] & lane_silent[2*c+1];
  end

  assign any_nz = smp_valid & (|lane_nz);

  zd_flag_select u_flags (
    .clk     (clk),
    .rst     (rst),
    .sel     (flag_sel),
    .lane_ok (lane_ok),
    .flag1   (zflag1),
    .flag2   (zflag2)
  );

  zd_automute #(.NCH(NCH)) u_mute (
    .clk       (clk),
    .rst       (rst),
    .en        (amute_en),
    .any_nz    (any_nz),
    .ch_silent (ch_silent),
    .mute      (mute)
  );

  // R7: single-lane code on a routed channel cannot flag
  p_routed_gate_r7: assert property (@(posedge clk) disable iff (rst)
    (flag_sel[3] && chan_routed[flag_sel[1:0]]) |=> (!zflag1 && !zflag2));
  // R11: reset leaves flags and mute clear
  p_reset_clear_r11: assert property (@(posedge clk)
    rst |=> (!zflag1 && !zflag2 && mute == '0));
endmodule

// File: tb/audio_zero_mute_tb.sv
`timescale 1ns/1ps
module audio_zero_mute_tb;
  localparam int W = 24;
  localparam int RL = 1024;

  logic clk = 0;
  logic rst;
  logic smp_valid;
  logic smp_ready;
  logic [8*W-1:0] smp_data;
  logic [3:0] chan_routed;
  logic [3:0] flag_sel;
  logic amute_en;
  logic zflag1, zflag2;
  logic [3:0] mute;

  int errors = 0;
  int checks = 0;
  int run [8];

  always #4 clk = ~clk;

  audio_zero_mute #(.SAMPLE_W(W), .RUN_LEN(RL)) u_dut (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_ready(smp_ready),
    .smp_data(smp_data), .chan_routed(chan_routed), .flag_sel(flag_sel),
    .amute_en(amute_en), .zflag1(zflag1), .zflag2(zflag2), .mute(mute)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Accepted beat; lanes set in nz carry non-zero samples.
  task automatic beat(input logic [7:0] nz);
    @(negedge clk);
    smp_valid = 1'b1;
    for (int l = 0; l < 8; l++) begin
      smp_data[l*W +: W] = nz[l] ? W'(l + 5) : '0;
      if (nz[l]) run[l] = 0;
      else if (run[l] < RL) run[l]++;
    end
  endtask

  // Beat without valid, carrying non-zero data on every lane.
  task automatic idle();
    @(negedge clk);
    smp_valid = 1'b0;
    for (int l = 0; l < 8; l++) smp_data[l*W +: W] = W'(l + 1);
  endtask

  task automatic zeros(input int n);
    for (int i = 0; i < n; i++) beat(8'h00);
  endtask

  function automatic logic [15:0] exp_masks(input logic [3:0] code);
    logic [7:0] a, b;
    a = 0; b = 0;
    if (code[3]) begin
      a = 8'(1) << (int'(code[1:0]) * 2 + int'(code[2]));
      b = a;
    end else begin
      case (code)
        4'd1: begin a = 8'b1111_1111; b = 8'b1111_1111; end
        4'd2: begin a = 8'b0101_0101; b = 8'b1010_1010; end
        4'd3: begin a = 8'b0000_0011; b = 8'b1111_1100; end
        4'd4: begin a = 8'b0000_0011; b = 8'b0000_1100; end
        4'd5: begin a = 8'b0000_0011; b = 8'b0011_0000; end
        4'd6: begin a = 8'b0000_0011; b = 8'b1100_0000; end
        4'd7: begin a = 8'b0000_1100; b = 8'b0011_0000; end
        default: begin a = 0; b = 0; end
      endcase
    end
    return {a, b};
  endfunction

  function automatic logic [1:0] exp_flags(input logic [3:0] code, input logic [3:0] rt);
    logic [7:0] ok, a, b;
    logic [15:0] m;
    for (int l = 0; l < 8; l++) ok[l] = (run[l] >= RL) && !rt[l/2];
    m = exp_masks(code);
    a = m[15:8]; b = m[7:0];
    return {(b != 0) && ((ok & b) == b), (a != 0) && ((ok & a) == a)};
  endfunction

  function automatic string req_of(input logic [3:0] code);
    if (code == 0) return "R3";
    if (code <= 2) return "R4";
    if (code <= 7) return "R5";
    return "R6";
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] pats [12];
    logic [1:0] ef;
    pats = '{8'h00, 8'h01, 8'h02, 8'h08, 8'h10, 8'h80, 8'hFF,
             8'h0F, 8'hF0, 8'h55, 8'hAA, 8'h3C};
    for (int l = 0; l < 8; l++) run[l] = 0;
    rst = 1; smp_valid = 0; smp_data = '0; chan_routed = 0;
    flag_sel = 0; amute_en = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R11 reset state, R3 default code, R8 ready
    chk(!zflag1 && !zflag2, "R11 reset flags", {zflag1, zflag2}, 0);
    chk(mute == 0, "R11 reset mute", mute, 0);
    chk(smp_ready, "R8 ready", smp_ready, 1);

    // R1/R8/R12 boundary of the run
    flag_sel = 4'd1;
    for (int i = 0; i < RL - 1; i++) begin
      beat(8'h00);
      if (i % 97 == 0) idle();
    end
    idle(); idle();
    chk(!zflag1 && !zflag2, "R1 after RUN_LEN-1 zeros", {zflag1, zflag2}, 0);
    beat(8'h00);
    idle();
    chk(!zflag1, "R12 one-cycle latency", zflag1, 0);
    idle();
    chk(zflag1 && zflag2, "R1 after RUN_LEN zeros", {zflag1, zflag2}, 3);
    zeros(500); idle(); idle();
    chk(zflag1 && zflag2, "R2 long silence holds", {zflag1, zflag2}, 3);

    // R3-R7 sweep over codes, routing and lane patterns
    for (int p = 0; p < 12; p++) begin
      zeros(RL);
      beat(pats[p]);
      idle();
      for (int s = 0; s < 16; s++) begin
        for (int r = 0; r < 16; r++) begin
          flag_sel = 4'(s); chan_routed = 4'(r);
          @(negedge clk);
          ef = exp_flags(4'(s), 4'(r));
          chk({zflag2, zflag1} == ef,
              r != 0 ? "R7 routing gate" : req_of(4'(s)),
              {zflag2, zflag1}, ef);
        end
      end
      flag_sel = 4'd8; chan_routed = 4'd0;
      beat(8'h00); idle(); idle();
      ef = exp_flags(4'd8, 4'd0);
      chk({zflag2, zflag1} == ef, "R2 restart after non-zero", {zflag2, zflag1}, ef);
    end

    // R9/R10 automute
    flag_sel = 4'd1; chan_routed = 0; amute_en = 1;
    beat(8'hFF);
    zeros(RL);
    idle();
    chk(mute == 0, "R9 mute latency", mute, 0);
    idle();
    chk(mute == 4'hF, "R9 all muted", mute, 4'hF);
    beat(8'h08);
    idle();
    chk(mute == 0, "R10 any non-zero releases all", mute, 0);
    idle(); idle(); idle();
    chk(mute == 0, "R10 no re-arm while saturated", mute, 0);
    zeros(RL - 1); idle(); idle();
    chk(mute == 0, "R9 one lane short", mute, 0);
    beat(8'h00); idle(); idle();
    chk(mute == 4'b0010, "R10 re-arm on new silence", mute, 4'b0010);
    amute_en = 0;
    @(negedge clk);
    chk(mute == 0, "R9 disable clears", mute, 0);

    // R11 mid-run reset clears counters
    rst = 1;
    @(negedge clk); @(negedge clk);
    rst = 0;
    for (int l = 0; l < 8; l++) run[l] = 0;
    @(negedge clk);
    chk(!zflag1 && !zflag2, "R11 reset flags mid-run", {zflag1, zflag2}, 0);
    beat(8'h00); idle(); idle();
    chk(!zflag1, "R11 counters cleared", zflag1, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule